// File: doc/BRIEF.md
# Single-Input-Change Test Pattern Generator

This block produces self-test stimulus vectors for a circuit under test, either in parallel onto its primary inputs or serially into the input of a scan chain. Between two back-to-back vectors exactly one bit changes, which keeps switching activity in the circuit under test low. The block makes no assumption about the circuit it drives.

An m-bit binary step counter feeds a Gray encoder. The Gray word is XORed into the low m bits of an n-bit seed word. While the counter runs through all 2^m values the seed holds still, so a whole counter period is made of single-bit steps. When the counter rolls over from all ones to zero, a shift-register feedback rule moves the seed to a new value. Bigger jumps between vectors therefore happen only at period boundaries. The seed can be loaded from outside. Reset, and any attempt to load an all-zero seed, put a fixed nonzero default seed in place.

Top module: `sic_tpg`

## Requirements
- R1: Asynchronous reset (rst_n low) clears the step counter, sets the seed to the default 8'h5A, and drives vec_out to 0 and vec_valid to 0. The first vector after reset is therefore 8'h5A.
- R2: Each emitted vector equals seed XOR {zeros, gray(cnt)}, where gray(c) = c ^ (c >> 1) occupies bits [CNT_W-1:0]. Bits [VEC_W-1:CNT_W] are equal to the seed.
- R3: Two vectors emitted on consecutive cycles inside one counter period differ in exactly one bit.
- R4: The seed changes only on a cycle that emits with cnt equal to all ones, or on a load. On that rollover it becomes {seed[VEC_W-2:0], ^(seed & 8'hB8)}, and cnt returns to 0.
- R5: When seed_ld is high, seed_din becomes the seed and cnt clears to 0. A seed_din of 0 loads the default 8'h5A instead.
- R6: When en is high and seed_ld is low, vec_valid is 1 in the next cycle and the counter advances. When en is low, vec_valid is 0 in the next cycle, while vec_out, the counter and the seed keep their values.
- R7: seed_ld takes priority over en. No vector is emitted in that cycle: vec_valid is 0 in the next cycle and vec_out is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Emit one vector this cycle |
| seed_ld | input | 1 | Load seed_din as the new seed and restart the period |
| seed_din | input | VEC_W | Seed value to load |
| vec_out | output | VEC_W | Registered test vector |
| vec_valid | output | 1 | vec_out was updated at the last edge |

## Verification
Every result of the block is due exactly one clock edge after the cycle that asks for it. A vector requested by en, the drop of vec_valid after en falls, and the effect of a load all appear at the next rising edge. The bench sets its inputs at the falling edge and pushes the expected vector and valid flag into a queue right away. A monitor pops one entry at each rising edge, waits a small delay, and compares. The single-bit-step check uses the monitor's own copy of the previous vector. It is applied only where the driver has marked the entry as lying inside a period.

// File: rtl/sic_pkg.sv
package sic_pkg;

  // Binary to reflected Gray conversion for any width up to 32.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/sic_gray_enc.sv
module sic_gray_enc #(
  parameter int W = 4
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);

  assign gray_o[W-1] = bin_i[W-1];

  for (genvar i = 0; i < W - 1; i++) begin : g_bit
    assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
  end

endmodule

// File: rtl/sic_step_counter.sv
module sic_step_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (step_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = step_i && !clr_i && (cnt_q == CNT_MAX);

endmodule

// File: rtl/sic_seed_reg.sv
module sic_seed_reg #(
  parameter int             W         = 8,
  parameter logic [W-1:0]   SEED_INIT = 'h5A,
  parameter logic [W-1:0]   TAPS      = 'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         adv_i,
  output logic [W-1:0] seed_o
);

  logic [W-1:0] seed_q, seed_d, seed_step;
  logic         fb;

  assign fb        = ^(seed_q & TAPS);
  assign seed_step = {seed_q[W-2:0], fb};

  always_comb begin
    seed_d = seed_q;
    if (load_i)     seed_d = (load_val_i == '0) ? SEED_INIT : load_val_i;
    else if (adv_i) seed_d = seed_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seed_q <= SEED_INIT;
    else        seed_q <= seed_d;
  end

  assign seed_o = seed_q;

endmodule

// File: rtl/sic_tpg.sv
module sic_tpg #(
  parameter int                 VEC_W     = 8,
  parameter int                 CNT_W     = 4,
  parameter logic [VEC_W-1:0]   SEED_INIT = 'h5A,
  parameter logic [VEC_W-1:0]   TAPS      = 'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             seed_ld,
  input  logic [VEC_W-1:0] seed_din,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid
);

  localparam int UP_W = VEC_W - CNT_W;

  logic [CNT_W-1:0] cnt_q, gray_w;
  logic [VEC_W-1:0] seed_q, mask_w;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             valid_q, valid_d;
  logic             step_w, wrap_w;

  assign step_w = en && !seed_ld;

  sic_step_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (seed_ld),
    .step_i (step_w),
    .cnt_o  (cnt_q),
    .wrap_o (wrap_w)
  );

  sic_gray_enc #(.W(CNT_W)) u_gray (
    .bin_i  (cnt_q),
    .gray_o (gray_w)
  );

  sic_seed_reg #(.W(VEC_W), .SEED_INIT(SEED_INIT), .TAPS(TAPS)) u_seed (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (seed_ld),
    .load_val_i (seed_din),
    .adv_i      (wrap_w),
    .seed_o     (seed_q)
  );

  if (UP_W == 0) begin : g_full
    assign mask_w = gray_w;
  end else begin : g_part
    assign mask_w = {{UP_W{1'b0}}, gray_w};
  end

  always_comb begin
    vec_d   = vec_q;
    valid_d = step_w;
    if (step_w) vec_d = seed_q ^ mask_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      vec_q   <= vec_d;
      valid_q <= valid_d;
    end
  end

  assign vec_out   = vec_q;
  assign vec_valid = valid_q;

endmodule

// File: rtl/sic_tpg_chk.sv
module sic_tpg_chk #(
  parameter int VEC_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             seed_ld,
  input logic             vec_valid,
  input logic [VEC_W-1:0] vec_out,
  input logic [CNT_W-1:0] cnt,
  input logic [VEC_W-1:0] seed
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R6
  a_r6_valid_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    en && !seed_ld |=> vec_valid);

  // R6
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !seed_ld |=> !vec_valid && $stable(vec_out) && $stable(seed));

  // R7
  a_r7_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ld |=> !vec_valid && $stable(vec_out) && cnt == '0);

  // R3
  a_r3_single_change: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && en && !seed_ld && cnt != '0
      |=> $countones(vec_out ^ $past(vec_out)) == 1);

  // R2
  a_r2_upper_follow_seed: assert property (@(posedge clk) disable iff (!rst_n)
    en && !seed_ld |=> vec_out[VEC_W-1:CNT_W] == $past(seed[VEC_W-1:CNT_W]));

  // R4
  a_r4_seed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_ld && !(en && cnt == CNT_MAX) |=> $stable(seed));

  // R5
  a_r5_seed_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    seed != '0);

endmodule

bind sic_tpg sic_tpg_chk #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .seed_ld   (seed_ld),
  .vec_valid (vec_valid),
  .vec_out   (vec_out),
  .cnt       (cnt_q),
  .seed      (seed_q)
);

// File: tb/sic_tpg_test.sv
module sic_tpg_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          VW         = 8;
  localparam int          CW         = 4;
  localparam logic [VW-1:0] DEF_SEED = 8'h5A;
  localparam logic [VW-1:0] POLY     = 8'hB8;
  localparam int          WD_CYCLES  = 5000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          seed_ld;
  logic [VW-1:0] seed_din;
  logic [VW-1:0] vec_out;
  logic          vec_valid;

  int errs   = 0;
  int checks = 0;
  bit done   = 1'b0;

  typedef struct {
    logic          v;
    logic [VW-1:0] vec;
    logic          sic;
    string         req;
  } item_t;

  item_t q[$];

  // bench-side model state
  logic [CW-1:0] m_cnt;
  logic [VW-1:0] m_seed;
  logic [VW-1:0] m_vec;
  logic          m_prev_step;
  string         next_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  sic_tpg #(.VEC_W(VW), .CNT_W(CW), .SEED_INIT(DEF_SEED), .TAPS(POLY)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .seed_ld   (seed_ld),
    .seed_din  (seed_din),
    .vec_out   (vec_out),
    .vec_valid (vec_valid)
  );

  function automatic logic [VW-1:0] lfsr_next(input logic [VW-1:0] s);
    return {s[VW-2:0], ^(s & POLY)};
  endfunction

  function automatic logic [CW-1:0] gray(input logic [CW-1:0] c);
    return c ^ (c >> 1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one cycle of stimulus plus the expected result for the next edge.
  task automatic cyc(input logic e, input logic l, input logic [VW-1:0] d);
    item_t it;
    logic  step;
    @(negedge clk);
    en = e; seed_ld = l; seed_din = d;
    step   = e && !l;
    it.sic = step && m_prev_step && (m_cnt != '0);
    it.req = (next_tag != "") ? next_tag : "R2";
    if (l) begin
      m_seed = (d == '0) ? DEF_SEED : d;
      m_cnt  = '0;
      it.req = "R7";
    end else if (step) begin
      m_vec = m_seed ^ {{(VW-CW){1'b0}}, gray(m_cnt)};
      if (m_cnt == {CW{1'b1}}) begin
        m_seed   = lfsr_next(m_seed);
        next_tag = "R4";
      end else begin
        next_tag = "";
      end
      m_cnt = m_cnt + 1'b1;
    end else begin
      it.req = "R6";
    end
    if (l) next_tag = "R5";
    it.v   = step;
    it.vec = m_vec;
    m_prev_step = step;
    q.push_back(it);
  endtask

  // Monitor: one expected entry per rising edge.
  logic [VW-1:0] prev_vec;
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(vec_valid == it.v, (it.v ? "R6" : (it.req == "R7" ? "R7" : "R6")),
            {7'd0, vec_valid}, {7'd0, it.v});
      check(vec_out == it.vec, it.req, vec_out, it.vec);
      if (it.sic)
        check($countones(vec_out ^ prev_vec) == 1, "R3", vec_out ^ prev_vec, 8'h01);
      prev_vec = vec_out;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; seed_ld = 1'b0; seed_din = '0;
    m_cnt = '0; m_seed = DEF_SEED; m_vec = '0; m_prev_step = 1'b0;
    next_tag = "R1"; prev_vec = '0;
    repeat (2) @(posedge clk);
    #2;
    // R1: reset state at the ports
    check(vec_out == '0, "R1", vec_out, '0);
    check(vec_valid == 1'b0, "R1", {7'd0, vec_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3/R4: a full period, the rollover, and a few more steps
    for (int i = 0; i < 21; i++) cyc(1'b1, 1'b0, '0);
    // R6: idle cycles hold the vector and drop valid
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, '0);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, '0);
    // R5/R7: load while enabled, then a full period plus rollover
    cyc(1'b1, 1'b1, 8'hC3);
    for (int i = 0; i < 18; i++) cyc(1'b1, 1'b0, '0);
    // R5: zero load falls back to the default seed
    cyc(1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, '0);
    // R6 with a pause in mid period, then continue across a rollover
    cyc(1'b0, 1'b0, '0);
    for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0, '0);
    // R5: load a seed with the upper bits set, short run
    cyc(1'b0, 1'b1, 8'hF0);
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, '0);
    cyc(1'b0, 1'b0, '0);
    repeat (3) @(posedge clk);
    #3;
    check(q.size() == 0, "R6", q.size(), '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule